// File: doc/BRIEF.md
# Serial Flash Command Front End

This block is the device side of a page-organised serial flash. It behaves as an SPI slave in mode 0. While chip select is low it collects a command frame: an opcode, a page or block address, a buffer byte address and, for program commands, a stream of data bytes. When chip select rises after a complete frame, it starts a self-timed operation. The operation can be one of four kinds:

- erase a single page to all ones;
- erase an aligned group of eight pages;
- copy a page into one of two byte buffers;
- load a page from one of those buffers.

While the operation runs, a status read reports the device as not ready. If SCK is held low after the ready bit has been shifted out, SO follows that bit live. A controller can therefore park the clock and wait for SO to rise.

The block owns the two byte buffers and a small register-array backend. It issues a one-cycle request on a simple interface that carries the operation, the page index and the buffer select. A byte-wide inspection port exposes the backend contents. SPI pins are sampled in the `clk_i` domain. The busy period of each operation kind is set by a parameter. The backend, in the meantime, walks the affected bytes at one per cycle.

Top module: `spi_flash_cmd`

## Requirements
- R1: After reset, req_valid_o and so_o are 0, every array and buffer byte is 00h, and a status read returns 80h.
- R2: Opcode D7h is a status read. SI is sampled on the rising SCK edge and SO changes on the falling edge, MSB first. Bit 7 is 1 when ready and 0 when busy, bits 6:0 are 0, and the byte repeats while SCK keeps toggling.
- R3: With SCK parked low after status bit 7 has been presented, SO shows the live ready value and rises when the running operation completes.
- R4: A frame is opcode [31:24], reserved [23:20], page [19:9] and buffer byte address [8:0]. Opcode 81h erases page [19:9] to FFh, with req_op_o = 1.
- R5: Opcode 50h takes a block number from frame bits [19:12] and sets the eight pages block*8 to block*8+7 to FFh. It gives req_op_o = 2 and req_page_o = block*8.
- R6: Opcode 53h copies the page into buffer 0 and 55h into buffer 1, with req_op_o = 3 and req_buf_o equal to the buffer number.
- R7: Opcode 82h (buffer 0) or 85h (buffer 1) writes each whole byte following the 32-bit frame into the buffer. Writing starts at the low BUF_AW bits of [8:0] and wraps from 2^BUF_AW-1 to 0. On CS rise the page is loaded with the buffer, with req_op_o = 4.
- R8: An operation starts only on a CS rise after at least 32 bits. A shorter frame or an unknown opcode starts nothing. req_valid_o is a single-cycle pulse in the cycle after the CS rise is sampled.
- R9: The device stays busy for exactly T_PG_ERASE, T_BLK_ERASE, T_XFER or T_PROG clock cycles from the launch edge, provided the value covers the bytes touched.
- R10: While busy, any opcode other than D7h is ignored. It causes no request, no buffer write and no array change.
- R11: so_o is 0 whenever cs_ni is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | SPI chip select, active low |
| sck_i | input | 1 | SPI serial clock |
| si_i | input | 1 | SPI serial data in |
| so_o | output | 1 | SPI serial data out |
| req_valid_o | output | 1 | One-cycle pulse when an operation starts |
| req_op_o | output | 3 | Operation code: 1 page erase, 2 block erase, 3 transfer, 4 program |
| req_page_o | output | 11 | Target page (first page for block erase) |
| req_buf_o | output | 1 | Buffer select for transfer and program |
| peek_page_i | input | PG_W (4) | Array page to inspect |
| peek_byte_i | input | BUF_AW (6) | Byte within the inspected page |
| peek_data_o | output | 8 | Inspected array byte |

## Verification
The assertions assume that cs_ni, sck_i and si_i change in step with clk_i. They also assume that every SCK level lasts at least two clock cycles, so that each edge is seen exactly once and chip select never moves in the same cycle as SCK. The stimulus therefore drives all SPI pins on the falling clk_i edge and holds each SCK level for two cycles. Chip select changes only while SCK is low, with two idle cycles around it.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  localparam int unsigned FRAME_BITS = 32;
  localparam int unsigned PAGE_AW    = 11;
  localparam int unsigned BADDR_W    = 9;

  localparam logic [7:0] OPC_STATUS    = 8'hD7;
  localparam logic [7:0] OPC_PG_ERASE  = 8'h81;
  localparam logic [7:0] OPC_BLK_ERASE = 8'h50;
  localparam logic [7:0] OPC_XFER_B0   = 8'h53;
  localparam logic [7:0] OPC_XFER_B1   = 8'h55;
  localparam logic [7:0] OPC_PROG_B0   = 8'h82;
  localparam logic [7:0] OPC_PROG_B1   = 8'h85;

  typedef enum logic [2:0] {
    OP_NONE      = 3'd0,
    OP_PG_ERASE  = 3'd1,
    OP_BLK_ERASE = 3'd2,
    OP_XFER      = 3'd3,
    OP_PROG      = 3'd4
  } op_e;

  typedef struct packed {
    op_e                op;
    logic [PAGE_AW-1:0] page;
    logic               buf_sel;
  } req_t;
endpackage

// File: rtl/sfc_spi_rx.sv
module sfc_spi_rx
  import sfc_pkg::*;
#(
  parameter int unsigned BUF_AW = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sck_i,
  input  logic              si_i,
  input  logic              busy_i,
  output logic              so_o,
  output logic              launch_o,
  output req_t              req_o,
  output logic              bw_en_o,
  output logic              bw_sel_o,
  output logic [BUF_AW-1:0] bw_addr_o,
  output logic [7:0]        bw_data_o
);
  localparam logic [5:0] NB_FULL = 6'(FRAME_BITS);
  localparam logic [5:0] NB_OPC  = 6'd7;
  localparam logic [5:0] NB_LAST = NB_FULL - 6'd1;

  logic               sck_q, cs_q;
  logic [18:0]        sh_q;
  logic [5:0]         nbits_q;
  logic [2:0]         dbits_q;
  logic [7:0]         opc_q;
  logic               ign_q, frame_q;
  logic               stat_pend_q, stat_mode_q;
  logic [2:0]         oidx_q;
  logic [PAGE_AW-1:0] page_q;
  logic [BUF_AW-1:0]  wptr_q;
  logic               bw_en_q;
  logic [BUF_AW-1:0]  bw_addr_q;
  logic [7:0]         bw_data_q;

  logic sck_rise, sck_fall, cs_rise, cs_fall;
  logic [7:0] byte_in;
  op_e  op;
  logic sel;

  assign sck_rise = ~cs_ni & sck_i & ~sck_q;
  assign sck_fall = ~cs_ni & ~sck_i & sck_q;
  assign cs_rise  = cs_ni & ~cs_q;
  assign cs_fall  = ~cs_ni & cs_q;
  assign byte_in  = {sh_q[6:0], si_i};

  function automatic op_e decode_op(logic [7:0] opc);
    case (opc)
      OPC_PG_ERASE:             return OP_PG_ERASE;
      OPC_BLK_ERASE:            return OP_BLK_ERASE;
      OPC_XFER_B0, OPC_XFER_B1: return OP_XFER;
      OPC_PROG_B0, OPC_PROG_B1: return OP_PROG;
      default:                  return OP_NONE;
    endcase
  endfunction

  assign op  = decode_op(opc_q);
  assign sel = (opc_q == OPC_XFER_B1) || (opc_q == OPC_PROG_B1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q       <= 1'b0;
      cs_q        <= 1'b1;
      sh_q        <= '0;
      nbits_q     <= '0;
      dbits_q     <= '0;
      opc_q       <= '0;
      ign_q       <= 1'b0;
      frame_q     <= 1'b0;
      stat_pend_q <= 1'b0;
      stat_mode_q <= 1'b0;
      oidx_q      <= '0;
      page_q      <= '0;
      wptr_q      <= '0;
      bw_en_q     <= 1'b0;
      bw_addr_q   <= '0;
      bw_data_q   <= '0;
    end else begin
      sck_q   <= sck_i;
      cs_q    <= cs_ni;
      bw_en_q <= 1'b0;
      if (cs_fall) begin
        nbits_q     <= '0;
        opc_q       <= '0;
        ign_q       <= 1'b0;
        frame_q     <= 1'b0;
        stat_pend_q <= 1'b0;
        stat_mode_q <= 1'b0;
      end else if (sck_rise) begin
        sh_q <= {sh_q[17:0], si_i};
        if (nbits_q != NB_FULL) nbits_q <= nbits_q + 6'd1;
        if (nbits_q == NB_OPC) begin
          opc_q       <= byte_in;
          ign_q       <= busy_i && (byte_in != OPC_STATUS);
          stat_pend_q <= (byte_in == OPC_STATUS);
        end
        if (nbits_q == NB_LAST) begin
          frame_q <= 1'b1;
          page_q  <= sh_q[18:8];
          wptr_q  <= byte_in[BUF_AW-1:0] | BUF_AW'({sh_q[7], 8'h00} >> 0);
          dbits_q <= '0;
        end
        if (frame_q) begin
          dbits_q <= dbits_q + 3'd1;
          if (dbits_q == 3'd7 && op == OP_PROG && !ign_q) begin
            bw_en_q   <= 1'b1;
            bw_addr_q <= wptr_q;
            bw_data_q <= byte_in;
            wptr_q    <= wptr_q + 1'b1;
          end
        end
      end else if (sck_fall) begin
        if (stat_pend_q) begin
          stat_pend_q <= 1'b0;
          stat_mode_q <= 1'b1;
          oidx_q      <= 3'd7;
        end else if (stat_mode_q) begin
          oidx_q <= oidx_q - 3'd1;
        end
      end
    end
  end

  // status bits 6:0 read as zero
  assign so_o = ~cs_ni & stat_mode_q & (oidx_q == 3'd7) & ~busy_i;

  assign launch_o    = cs_rise & frame_q & ~ign_q & (op != OP_NONE) & ~busy_i;
  assign req_o.op      = op;
  assign req_o.page    = (op == OP_BLK_ERASE) ? {page_q[PAGE_AW-1:3], 3'b000} : page_q;
  assign req_o.buf_sel = sel;

  assign bw_en_o   = bw_en_q;
  assign bw_sel_o  = sel;
  assign bw_addr_o = bw_addr_q;
  assign bw_data_o = bw_data_q;
endmodule

// File: rtl/sfc_bufs.sv
module sfc_bufs #(
  parameter int unsigned BUF_AW = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_we_i,
  input  logic              host_sel_i,
  input  logic [BUF_AW-1:0] host_addr_i,
  input  logic [7:0]        host_data_i,
  input  logic              eng_we_i,
  input  logic              eng_sel_i,
  input  logic [BUF_AW-1:0] eng_addr_i,
  input  logic [7:0]        eng_data_i,
  output logic [7:0]        eng_rdata_o
);
  localparam int unsigned DEPTH = 1 << BUF_AW;
  localparam int unsigned NBUF  = 2;

  logic [7:0] rd_arr [NBUF];

  for (genvar g = 0; g < NBUF; g++) begin : g_buf
    logic [7:0] mem_q [DEPTH];
    logic       eng_hit, host_hit;

    assign eng_hit  = eng_we_i && (eng_sel_i == 1'(g));
    assign host_hit = host_we_i && (host_sel_i == 1'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      end else if (eng_hit) begin
        mem_q[eng_addr_i] <= eng_data_i;
      end else if (host_hit) begin
        mem_q[host_addr_i] <= host_data_i;
      end
    end

    assign rd_arr[g] = mem_q[eng_addr_i];
  end

  assign eng_rdata_o = rd_arr[eng_sel_i];
endmodule

// File: rtl/sfc_array.sv
module sfc_array #(
  parameter int unsigned NUM_PAGES = 16,
  parameter int unsigned BUF_AW    = 6,
  localparam int unsigned PG_W     = $clog2(NUM_PAGES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [PG_W-1:0]   page_i,
  input  logic [BUF_AW-1:0] byte_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic [PG_W-1:0]   peek_page_i,
  input  logic [BUF_AW-1:0] peek_byte_i,
  output logic [7:0]        peek_data_o
);
  localparam int unsigned SIZE = NUM_PAGES << BUF_AW;

  logic [7:0] mem_q [SIZE];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < SIZE; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[{page_i, byte_i}] <= wdata_i;
    end
  end

  assign rdata_o     = mem_q[{page_i, byte_i}];
  assign peek_data_o = mem_q[{peek_page_i, peek_byte_i}];
endmodule

// File: rtl/sfc_engine.sv
module sfc_engine
  import sfc_pkg::*;
#(
  parameter int unsigned BUF_AW      = 6,
  parameter int unsigned PG_W        = 4,
  parameter int unsigned T_PG_ERASE  = 300,
  parameter int unsigned T_BLK_ERASE = 800,
  parameter int unsigned T_XFER      = 200,
  parameter int unsigned T_PROG      = 400
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  op_e               op_i,
  input  logic [PG_W-1:0]   page_i,
  input  logic              sel_i,
  output logic              busy_o,
  output logic              mem_we_o,
  output logic [PG_W-1:0]   mem_page_o,
  output logic [BUF_AW-1:0] mem_byte_o,
  output logic [7:0]        mem_wdata_o,
  input  logic [7:0]        mem_rdata_i,
  output logic              buf_we_o,
  output logic              buf_sel_o,
  output logic [7:0]        buf_wdata_o,
  input  logic [7:0]        buf_rdata_i
);
  localparam int unsigned DEPTH = 1 << BUF_AW;
  localparam int unsigned IW    = $clog2(8 * DEPTH) + 1;
  localparam logic [IW-1:0] LEN_PG  = IW'(DEPTH);
  localparam logic [IW-1:0] LEN_BLK = IW'(8 * DEPTH);

  logic            busy_q, sel_q;
  op_e             op_q;
  logic [PG_W-1:0] pg_q;
  logic [IW-1:0]   idx_q;
  logic [31:0]     cnt_q;
  logic [IW-1:0]   len;
  logic            walking;
  logic [PG_W-1:0] pg_off;

  function automatic logic [31:0] op_time(op_e op);
    case (op)
      OP_PG_ERASE:  return 32'(T_PG_ERASE);
      OP_BLK_ERASE: return 32'(T_BLK_ERASE);
      OP_XFER:      return 32'(T_XFER);
      OP_PROG:      return 32'(T_PROG);
      default:      return 32'd1;
    endcase
  endfunction

  assign len     = (op_q == OP_BLK_ERASE) ? LEN_BLK : LEN_PG;
  assign walking = busy_q && (idx_q < len);
  assign pg_off  = PG_W'(idx_q >> BUF_AW);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sel_q  <= 1'b0;
      op_q   <= OP_NONE;
      pg_q   <= '0;
      idx_q  <= '0;
      cnt_q  <= '0;
    end else if (launch_i) begin
      busy_q <= 1'b1;
      sel_q  <= sel_i;
      op_q   <= op_i;
      pg_q   <= page_i;
      idx_q  <= '0;
      cnt_q  <= op_time(op_i) - 32'd1;
    end else if (busy_q) begin
      if (walking) idx_q <= idx_q + 1'b1;
      if (cnt_q != 32'd0) cnt_q <= cnt_q - 32'd1;
      else if (!walking) busy_q <= 1'b0;
    end
  end

  // one byte per cycle; program result equals erase-then-load
  assign mem_page_o  = (op_q == OP_BLK_ERASE) ? pg_q + pg_off : pg_q;
  assign mem_byte_o  = idx_q[BUF_AW-1:0];
  assign mem_we_o    = walking && (op_q != OP_XFER);
  assign mem_wdata_o = (op_q == OP_PROG) ? buf_rdata_i : 8'hFF;
  assign buf_we_o    = walking && (op_q == OP_XFER);
  assign buf_sel_o   = sel_q;
  assign buf_wdata_o = mem_rdata_i;
  assign busy_o      = busy_q;
endmodule

// File: rtl/spi_flash_cmd.sv
module spi_flash_cmd
  import sfc_pkg::*;
#(
  parameter int unsigned NUM_PAGES   = 16,
  parameter int unsigned BUF_AW      = 6,
  parameter int unsigned T_PG_ERASE  = 300,
  parameter int unsigned T_BLK_ERASE = 800,
  parameter int unsigned T_XFER      = 200,
  parameter int unsigned T_PROG      = 400,
  localparam int unsigned PG_W       = $clog2(NUM_PAGES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cs_ni,
  input  logic               sck_i,
  input  logic               si_i,
  output logic               so_o,
  output logic               req_valid_o,
  output logic [2:0]         req_op_o,
  output logic [PAGE_AW-1:0] req_page_o,
  output logic               req_buf_o,
  input  logic [PG_W-1:0]    peek_page_i,
  input  logic [BUF_AW-1:0]  peek_byte_i,
  output logic [7:0]         peek_data_o
);
  logic              busy, launch;
  req_t              req;
  logic              bw_en, bw_sel;
  logic [BUF_AW-1:0] bw_addr;
  logic [7:0]        bw_data;
  logic              mem_we;
  logic [PG_W-1:0]   mem_page;
  logic [BUF_AW-1:0] mem_byte;
  logic [7:0]        mem_wdata, mem_rdata;
  logic              eb_we, eb_sel;
  logic [7:0]        eb_wdata, eb_rdata;
  logic              req_valid_q, req_buf_q;
  logic [2:0]        req_op_q;
  logic [PAGE_AW-1:0] req_page_q;

  sfc_spi_rx #(.BUF_AW(BUF_AW)) u_rx (
    .clk_i, .rst_ni, .cs_ni, .sck_i, .si_i,
    .busy_i    (busy),
    .so_o,
    .launch_o  (launch),
    .req_o     (req),
    .bw_en_o   (bw_en),
    .bw_sel_o  (bw_sel),
    .bw_addr_o (bw_addr),
    .bw_data_o (bw_data)
  );

  sfc_engine #(
    .BUF_AW(BUF_AW), .PG_W(PG_W),
    .T_PG_ERASE(T_PG_ERASE), .T_BLK_ERASE(T_BLK_ERASE),
    .T_XFER(T_XFER), .T_PROG(T_PROG)
  ) u_eng (
    .clk_i, .rst_ni,
    .launch_i    (launch),
    .op_i        (req.op),
    .page_i      (req.page[PG_W-1:0]),
    .sel_i       (req.buf_sel),
    .busy_o      (busy),
    .mem_we_o    (mem_we),
    .mem_page_o  (mem_page),
    .mem_byte_o  (mem_byte),
    .mem_wdata_o (mem_wdata),
    .mem_rdata_i (mem_rdata),
    .buf_we_o    (eb_we),
    .buf_sel_o   (eb_sel),
    .buf_wdata_o (eb_wdata),
    .buf_rdata_i (eb_rdata)
  );

  sfc_bufs #(.BUF_AW(BUF_AW)) u_bufs (
    .clk_i, .rst_ni,
    .host_we_i   (bw_en),
    .host_sel_i  (bw_sel),
    .host_addr_i (bw_addr),
    .host_data_i (bw_data),
    .eng_we_i    (eb_we),
    .eng_sel_i   (eb_sel),
    .eng_addr_i  (mem_byte),
    .eng_data_i  (eb_wdata),
    .eng_rdata_o (eb_rdata)
  );

  sfc_array #(.NUM_PAGES(NUM_PAGES), .BUF_AW(BUF_AW)) u_array (
    .clk_i, .rst_ni,
    .we_i        (mem_we),
    .page_i      (mem_page),
    .byte_i      (mem_byte),
    .wdata_i     (mem_wdata),
    .rdata_o     (mem_rdata),
    .peek_page_i,
    .peek_byte_i,
    .peek_data_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_valid_q <= 1'b0;
      req_op_q    <= '0;
      req_page_q  <= '0;
      req_buf_q   <= 1'b0;
    end else begin
      req_valid_q <= launch;
      if (launch) begin
        req_op_q   <= req.op;
        req_page_q <= req.page;
        req_buf_q  <= req.buf_sel;
      end
    end
  end

  assign req_valid_o = req_valid_q;
  assign req_op_o    = req_op_q;
  assign req_page_o  = req_page_q;
  assign req_buf_o   = req_buf_q;
endmodule

// File: rtl/spi_flash_cmd_chk.sv
module spi_flash_cmd_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_ni,
  input logic       so_o,
  input logic       req_valid_o,
  input logic [2:0] req_op_o,
  input logic       busy
);
  a_r11_so_quiet_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |-> !so_o);

  a_r8_req_after_cs_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> ($past(cs_ni) && !$past(cs_ni, 2)));

  a_r8_req_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |=> !req_valid_o);

  a_r10_req_from_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> !$past(busy));

  a_r9_busy_with_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> busy);

  a_r4_req_op_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> (req_op_o >= 3'd1 && req_op_o <= 3'd4));
endmodule

bind spi_flash_cmd spi_flash_cmd_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cs_ni       (cs_ni),
  .so_o        (so_o),
  .req_valid_o (req_valid_o),
  .req_op_o    (req_op_o),
  .busy        (busy)
);

// File: tb/spi_flash_cmd_tb_top.sv
module spi_flash_cmd_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 2;
  localparam int T_PE = 300, T_BE = 800, T_XF = 200, T_PG = 400;
  localparam int NV = 6;
  localparam int TV_OPC [NV] = '{'h81, 'h50, 'h53, 'h55, 'h82, 'h85};
  localparam int TV_PG  [NV] = '{2, 8, 5, 6, 4, 7};
  localparam int TV_T   [NV] = '{T_PE, T_BE, T_XF, T_XF, T_PG, T_PG};
  localparam int TV_OP  [NV] = '{1, 2, 3, 3, 4, 4};
  localparam int TV_BUF [NV] = '{0, 0, 0, 1, 0, 1};

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, si = 1'b0;
  logic so, req_valid, req_buf;
  logic [2:0] req_op;
  logic [10:0] req_page;
  logic [3:0] peek_pg = '0;
  logic [5:0] peek_by = '0;
  logic [7:0] peek_d;

  int cyc = 0, n_chk = 0, n_bad = 0, req_cnt = 0;
  int last_op = 0, last_pg = 0, last_buf = 0;
  bit done = 0;

  spi_flash_cmd #(
    .T_PG_ERASE(T_PE), .T_BLK_ERASE(T_BE), .T_XFER(T_XF), .T_PROG(T_PG)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .si_i(si), .so_o(so),
    .req_valid_o(req_valid), .req_op_o(req_op), .req_page_o(req_page), .req_buf_o(req_buf),
    .peek_page_i(peek_pg), .peek_byte_i(peek_by), .peek_data_o(peek_d)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (req_valid) begin
    req_cnt++; last_op = int'(req_op); last_pg = int'(req_page); last_buf = int'(req_buf);
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_bit(logic b);
    si = b; tick(HALF); sck = 1'b1; tick(HALF); sck = 1'b0;
  endtask

  task automatic spi_byte(logic [7:0] v);
    for (int i = 7; i >= 0; i--) spi_bit(v[i]);
  endtask

  task automatic frame(int opc, int pg, int ba, int nbits);
    logic [31:0] w = {8'(opc), 4'h0, 11'(pg), 9'(ba)};
    cs_n = 1'b0; tick(HALF);
    for (int i = 31; i > 31 - nbits; i--) spi_bit(w[i]);
  endtask

  task automatic cs_up();
    tick(HALF); cs_n = 1'b1; tick(HALF);
  endtask

  task automatic read_status(int nb, output logic [15:0] v);
    v = '0;
    cs_n = 1'b0; tick(HALF);
    spi_byte(8'hD7);
    tick(HALF); v[nb-1] = so;
    for (int i = nb - 2; i >= 0; i--) begin
      sck = 1'b1; tick(HALF); sck = 1'b0; tick(HALF); v[i] = so;
    end
    cs_up();
  endtask

  task automatic wait_ready();
    cs_n = 1'b0; tick(HALF);
    spi_byte(8'hD7); tick(HALF);
    for (int i = 0; i < 2000 && so !== 1'b1; i++) tick(1);
    cs_up();
  endtask

  // launch a frame, then park SCK after the status opcode and time the ready rise
  task automatic timed_op(int opc, int pg, int t_exp, string tag);
    int c0;
    frame(opc, pg, 0, 32);
    tick(HALF); cs_n = 1'b1; c0 = cyc;
    tick(2);
    cs_n = 1'b0; tick(HALF);
    spi_byte(8'hD7); tick(HALF);
    chk({tag, " R3 busy bit7 low"}, int'(so), 0);
    while (so !== 1'b1 && cyc - c0 < t_exp + 50) tick(1);
    chk({tag, " R9/R3 ready rise cycle"}, cyc - c0, t_exp + 1);
    cs_up();
  endtask

  task automatic peek(int pg, int by, int exp, string tag);
    peek_pg = 4'(pg); peek_by = 6'(by); #1;
    chk(tag, int'(peek_d), exp);
  endtask

  initial begin
    int rc;
    logic [15:0] st;
    tick(3);
    chk("R1 so after reset", int'(so), 0);
    chk("R1 req_valid after reset", int'(req_valid), 0);
    peek(0, 0, 8'h00, "R1 array reset");
    rst_n = 1'b1; tick(3);
    read_status(8, st);
    chk("R1 status after reset", int'(st), 'h80);

    for (int k = 0; k < NV; k++) begin
      rc = req_cnt;
      timed_op(TV_OPC[k], TV_PG[k], TV_T[k], $sformatf("vec%0d", k));
      chk("R8 one request per frame", req_cnt - rc, 1);
      chk("R4/R5/R6/R7 req_op", last_op, TV_OP[k]);
      chk("R5 req_page", last_pg, TV_PG[k]);
      chk("R6 req_buf", last_buf, TV_BUF[k]);
    end
    peek(2, 17, 8'hFF, "R4 page erased");
    peek(8, 0, 8'hFF, "R5 first block page");
    peek(15, 63, 8'hFF, "R5 last block page");
    peek(7, 5, 8'h00, "R5 outside block untouched");

    // R7: buffer 0 write from byte 62 wraps to 0
    frame('h82, 1, 62, 32);
    spi_byte(8'hA1); spi_byte(8'hA2); spi_byte(8'hA3); spi_byte(8'hA4);
    cs_up(); wait_ready();
    peek(1, 62, 8'hA1, "R7 start byte");
    peek(1, 63, 8'hA2, "R7 last byte");
    peek(1, 0, 8'hA3, "R7 wrap byte 0");
    peek(1, 1, 8'hA4, "R7 wrap byte 1");
    peek(1, 2, 8'h00, "R7 unwritten byte");

    // R8: short frame aborts
    rc = req_cnt;
    frame('h81, 3, 0, 20); cs_up(); tick(4);
    chk("R8 short frame no request", req_cnt - rc, 0);
    read_status(8, st);
    chk("R8 short frame stays ready", int'(st), 'h80);
    peek(3, 20, 8'h00, "R8 short frame no erase");

    // R4 then R6: erase page 1, copy into buffer 1, load page 3 with no data
    frame('h81, 1, 0, 32); cs_up(); wait_ready();
    peek(1, 62, 8'hFF, "R4 erase overwrites data");
    frame('h55, 1, 0, 32); cs_up(); wait_ready();
    frame('h85, 3, 0, 32); cs_up(); wait_ready();
    peek(3, 20, 8'hFF, "R6 transfer then program");
    peek(3, 0, 8'hFF, "R6 transfer byte 0");

    // R10: program while busy is ignored
    rc = req_cnt;
    frame('h81, 0, 0, 32); cs_up(); tick(4);
    frame('h82, 0, 0, 32); spi_byte(8'h55); cs_up();
    chk("R10 ignored while busy", req_cnt - rc, 1);
    wait_ready();
    peek(0, 0, 8'hFF, "R10 no program after busy");
    chk("R10 no late request", req_cnt - rc, 1);

    // R2: status byte repeats
    read_status(16, st);
    chk("R2 two status bytes", int'(st), 'h8080);
    chk("R11 so idle with cs high", int'(so), 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule